// File: doc/BRIEF.md
# I2C Register Target with Staged Commit

This block is an I2C target for a bank of byte-wide control registers. SCL and SDA are sampled with the system clock. An open-drain pull-down enable drives SDA low. A host first sends the device address with the write direction. It then sends any number of (register index, value) pairs. Each value is stored in a holding register. The live command outputs take the holding values only when a STOP appears on the bus. This lets a host stage settings for several devices, using repeated STARTs to reach each one, and have all of them take effect together at the final STOP.

Reads use a stored pointer. The host writes an index, then issues a repeated START with the read direction and clocks out one byte, MSB first. Reads of a command index return the holding copy, so staged data can be checked before it is committed. Status bytes are supplied on a parallel input and are read-only. The pointer is kept across transactions, so a register can be polled by sending only START and the read address.

Top module: `i2c_shadow_regs`

## Requirements
- R1: An address byte is the 7-bit device address followed by a direction bit (1 = read). When bits 7:1 equal `DEV_ADDR`, the block pulls SDA low for the ninth clock. On any other address it leaves SDA released and ignores all bytes until the next START.
- R2: In a write transaction the block acknowledges each register-index byte and each value byte by pulling SDA low during the ninth clock.
- R3: A value byte is stored in the holding register selected by the latest index when its acknowledge is issued. `cmd_q` does not change at that point.
- R4: On a STOP, every command byte k (`cmd_q[8k+7:8k]`, indices 0x00 to `NUM_CMD-1`) takes its holding value. `cmd_q` changes at no other time.
- R5: A repeated START that addresses another device does not discard staged values. They are committed at the next STOP.
- R6: Bytes after the address alternate strictly between index and value. The index never auto-increments, so registers that are not named keep their old value.
- R7: After an index write, a repeated START with the read address makes the block drive 8 data bits MSB first. Each bit changes only while SCL is low.
- R8: The read pointer persists until a new index is written. A host ACK after a read byte repeats the same register. A host NACK ends the read and releases SDA, and a STOP is not needed.
- R9: Reading a command index before STOP returns the staged holding value.
- R10: Status byte k (`stat_d[8k+7:8k]`) reads at index 0x10+k. Writes to those indices are acknowledged and change nothing.
- R11: Writes to indices outside the command and status ranges are acknowledged and ignored. Reads there return 0x00.
- R12: After reset `cmd_q` is all zero and SDA is released. `sda_oe` changes only after an SCL falling edge, a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| stat_d | input | NUM_STAT*8 | Read-only status bytes, byte k at index 0x10+k |
| cmd_q | output | NUM_CMD*8 | Committed command bytes, byte k for index k |

## Verification
The bench keeps a reference image of the holding and command registers and compares the command outputs against it on every clock. A design that commits early on a value acknowledge, or on a repeated START, shows up as soon as it happens. Targeted sequences check the following cases:
- Read-back before STOP: a design that reads the command copy returns the old value.
- Repeated START to a foreign address: a design that acknowledges it, or drops the staged data, is caught.
- Polling with host ACK: a design that auto-increments returns the wrong register.
- Accesses to the boundary indices 0x0D and 0x0E, the status range, and an unmapped index: a decode error there either corrupts a neighbouring register or returns a non-zero byte.

// File: rtl/i2c_shadow_pkg.sv
package i2c_shadow_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_TX,
        ST_TX,
        ST_ACK_RX
    } link_state_t;

    typedef enum logic [1:0] {
        ROLE_ADDR,
        ROLE_SUB,
        ROLE_DATA
    } byte_role_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic       en;
        logic [7:0] ptr;
        logic [7:0] data;
    } wr_req_t;

    function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
        return b[7:1] == dev;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_shadow_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_sh;
    logic [TOP:0] sda_sh;
    logic         scl_d;
    logic         sda_d;
    logic         scl_s;
    logic         sda_s;

    // Lines idle high, so reset values create no false events.
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[TOP-1:0], scl_i};
            sda_sh <= {sda_sh[TOP-1:0], sda_i};
            scl_d  <= scl_sh[TOP];
            sda_d  <= sda_sh[TOP];
        end
    end

    assign scl_s = scl_sh[TOP];
    assign sda_s = sda_sh[TOP];

    always_comb begin
        ev.start = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop  = scl_s & scl_d & ~sda_d & sda_s;
        ev.rise  = scl_s & ~scl_d;
        ev.fall  = ~scl_s & scl_d;
        ev.sda   = sda_s;
    end

endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
    import i2c_shadow_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h34
) (
    input  logic        clk,
    input  logic        rst,
    input  bus_ev_t     ev,
    input  logic [7:0]  rd_byte,
    output wr_req_t     wr,
    output logic [7:0]  ptr_q,
    output logic        commit,
    output logic        sda_oe,
    output link_state_t state_o
);
    localparam logic [3:0] BYTE_BITS = 4'd8;

    link_state_t state;
    byte_role_t  role;
    logic        rd_dir;
    logic        host_ack;
    logic [3:0]  cnt;
    logic [7:0]  rx_sh;
    logic [7:0]  tx_sh;
    logic [7:0]  ptr;
    logic        oe;

    wire byte_in = (state == ST_RX) && ev.fall && (cnt == BYTE_BITS);

    always_comb begin
        wr.en   = byte_in && (role == ROLE_DATA);
        wr.ptr  = ptr;
        wr.data = rx_sh;
    end

    assign commit  = ev.stop;
    assign ptr_q   = ptr;
    assign sda_oe  = oe;
    assign state_o = state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            role     <= ROLE_ADDR;
            rd_dir   <= 1'b0;
            host_ack <= 1'b0;
            cnt      <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            ptr      <= '0;
            oe       <= 1'b0;
        end else if (ev.start) begin
            state <= ST_RX;
            role  <= ROLE_ADDR;
            cnt   <= '0;
            oe    <= 1'b0;
        end else if (ev.stop) begin
            state <= ST_IDLE;
            oe    <= 1'b0;
        end else begin
            unique case (state)
                ST_RX: begin
                    if (ev.rise && cnt < BYTE_BITS) begin
                        rx_sh <= {rx_sh[6:0], ev.sda};
                        cnt   <= cnt + 4'd1;
                    end else if (byte_in) begin
                        cnt <= '0;
                        unique case (role)
                            ROLE_ADDR: begin
                                if (addr_hit(rx_sh, DEV_ADDR)) begin
                                    oe     <= 1'b1;
                                    rd_dir <= rx_sh[0];
                                    role   <= ROLE_SUB;
                                    state  <= ST_ACK_TX;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            ROLE_SUB: begin
                                ptr   <= rx_sh;
                                oe    <= 1'b1;
                                role  <= ROLE_DATA;
                                state <= ST_ACK_TX;
                            end
                            default: begin
                                oe    <= 1'b1;
                                role  <= ROLE_SUB;
                                state <= ST_ACK_TX;
                            end
                        endcase
                    end
                end
                ST_ACK_TX: begin
                    if (ev.fall) begin
                        cnt <= '0;
                        if (rd_dir) begin
                            tx_sh <= rd_byte;
                            oe    <= ~rd_byte[7];
                            state <= ST_TX;
                        end else begin
                            oe    <= 1'b0;
                            state <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.rise) begin
                        cnt <= cnt + 4'd1;
                    end else if (ev.fall) begin
                        if (cnt == BYTE_BITS) begin
                            oe    <= 1'b0;
                            state <= ST_ACK_RX;
                        end else begin
                            tx_sh <= {tx_sh[6:0], 1'b0};
                            oe    <= ~tx_sh[6];
                        end
                    end
                end
                ST_ACK_RX: begin
                    if (ev.rise) begin
                        host_ack <= ~ev.sda;
                    end else if (ev.fall) begin
                        cnt <= '0;
                        if (host_ack) begin
                            tx_sh <= rd_byte;
                            oe    <= ~rd_byte[7];
                            state <= ST_TX;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    oe <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/i2c_shadow_bank.sv
module i2c_shadow_bank
    import i2c_shadow_pkg::*;
#(
    parameter int NUM_CMD   = 14,
    parameter int NUM_STAT  = 2,
    parameter int STAT_BASE = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  wr_req_t               wr,
    input  logic                  commit,
    input  logic [7:0]            rd_ptr,
    input  logic [NUM_STAT*8-1:0] stat_d,
    output logic [7:0]            rd_byte,
    output logic [NUM_CMD*8-1:0]  hold_q,
    output logic [NUM_CMD*8-1:0]  cmd_q
);
    localparam int CMD_W  = NUM_CMD * 8;
    localparam int STAT_W = NUM_STAT * 8;

    for (genvar g = 0; g < NUM_CMD; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                hold_q[g*8 +: 8] <= '0;
                cmd_q[g*8 +: 8]  <= '0;
            end else begin
                if (wr.en && wr.ptr == 8'(g)) begin
                    hold_q[g*8 +: 8] <= wr.data;
                end
                if (commit) begin
                    cmd_q[g*8 +: 8] <= hold_q[g*8 +: 8];
                end
            end
        end
    end

    // Unmapped indices fall through to zero.
    always_comb begin
        rd_byte = 8'h00;
        for (int i = 0; i < NUM_CMD; i++) begin
            if (rd_ptr == 8'(i)) rd_byte = hold_q[i*8 +: 8];
        end
        for (int j = 0; j < NUM_STAT; j++) begin
            if (rd_ptr == 8'(STAT_BASE + j)) rd_byte = stat_d[j*8 +: 8];
        end
    end

    initial begin
        if (CMD_W > STAT_BASE * 8 || STAT_W > (256 - STAT_BASE) * 8)
            $display("i2c_shadow_bank: register ranges overlap or overflow the index space");
    end

endmodule

// File: rtl/i2c_shadow_regs.sv
module i2c_shadow_regs
    import i2c_shadow_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h34,
    parameter int         NUM_CMD   = 14,
    parameter int         NUM_STAT  = 2,
    parameter int         STAT_BASE = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    input  logic [NUM_STAT*8-1:0] stat_d,
    output logic [NUM_CMD*8-1:0]  cmd_q
);
    bus_ev_t     ev;
    wr_req_t     wr;
    logic [7:0]  ptr;
    logic [7:0]  rd_byte;
    logic        commit;
    link_state_t state;
    logic [NUM_CMD*8-1:0] hold_q;

    i2c_line_sync #(.SYNC_STAGES(2)) sync_i (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_link_fsm #(.DEV_ADDR(DEV_ADDR)) fsm_i (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .rd_byte (rd_byte),
        .wr      (wr),
        .ptr_q   (ptr),
        .commit  (commit),
        .sda_oe  (sda_oe),
        .state_o (state)
    );

    i2c_shadow_bank #(
        .NUM_CMD   (NUM_CMD),
        .NUM_STAT  (NUM_STAT),
        .STAT_BASE (STAT_BASE)
    ) bank_i (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .commit  (commit),
        .rd_ptr  (ptr),
        .stat_d  (stat_d),
        .rd_byte (rd_byte),
        .hold_q  (hold_q),
        .cmd_q   (cmd_q)
    );

endmodule

// File: rtl/i2c_shadow_regs_chk.sv
module i2c_shadow_regs_chk
    import i2c_shadow_pkg::*;
#(
    parameter int NUM_CMD = 14
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 ev_start,
    input logic                 ev_stop,
    input logic                 ev_fall,
    input logic                 sda_oe,
    input link_state_t          state,
    input logic [NUM_CMD*8-1:0] hold_q,
    input logic [NUM_CMD*8-1:0] cmd_q
);
    AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> $past(ev_fall || ev_start || ev_stop)); // R12

    AST_CMD_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        !$stable(cmd_q) |-> $past(ev_stop)); // R4

    AST_HOLD_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        !$stable(hold_q) |-> $past(ev_fall)); // R3

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe); // R1

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> !sda_oe); // R8

endmodule

bind i2c_shadow_regs i2c_shadow_regs_chk #(.NUM_CMD(NUM_CMD)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .ev_start (ev.start),
    .ev_stop  (ev.stop),
    .ev_fall  (ev.fall),
    .sda_oe   (sda_oe),
    .state    (state),
    .hold_q   (hold_q),
    .cmd_q    (cmd_q)
);

// File: tb/i2c_shadow_regs_tb_top.sv
module i2c_shadow_regs_tb_top;
    localparam logic [6:0] DEV = 7'h34;
    localparam int NC = 14;
    localparam int NS = 2;
    localparam int SB = 16;
    localparam int Q  = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_bus;
    logic [NS*8-1:0] stat_d = 16'hA53C;
    logic [NC*8-1:0] cmd_q;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_en = 1'b0;
    bit ended = 1'b0;
    int ref_hold[NC];
    int ref_cmd[NC];

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_shadow_regs #(.DEV_ADDR(DEV), .NUM_CMD(NC), .NUM_STAT(NS), .STAT_BASE(SB)) dut_i (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_m),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe),
        .stat_d (stat_d),
        .cmd_q  (cmd_q)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic int model_read(input int p);
        if (p < NC) return ref_hold[p];
        if (p >= SB && p < SB + NS) return int'((stat_d >> ((p - SB) * 8)) & 16'h00FF);
        return 0;
    endfunction

    // Reference comparison of the committed bank on every clock (R4, R3).
    always @(negedge clk) begin
        if (cmp_en) begin
            int bad = -1;
            for (int i = 0; i < NC; i++)
                if (bad < 0 && int'(cmd_q[i*8 +: 8]) != ref_cmd[i]) bad = i;
            if (bad >= 0) chk(1'b0, "R4 command bank vs model", int'(cmd_q[bad*8 +: 8]), ref_cmd[bad]);
            else chk(1'b1, "R4", 0, 0);
        end
    end

    task automatic wq();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        cmp_en = 1'b0;
        sda_m = 1'b1; wq();
        for (int i = 0; i < NC; i++) ref_cmd[i] = ref_hold[i];
        cmp_en = 1'b1;
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        b = sda_bus; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        ack = !a;
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit host_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(!host_ack);
    endtask

    task automatic send_addr(input logic [6:0] a, input logic rd, input bit exp_ack, input string tag);
        bit ack;
        send_byte({a, rd}, ack);
        chk(ack == exp_ack, tag, int'(ack), int'(exp_ack));
    endtask

    task automatic send_sub(input logic [7:0] s);
        bit ack;
        send_byte(s, ack);
        chk(ack, "R2 index byte ack", int'(ack), 1);
    endtask

    task automatic write_pair(input logic [7:0] s, input logic [7:0] d);
        bit ack;
        send_sub(s);
        send_byte(d, ack);
        chk(ack, "R2 value byte ack", int'(ack), 1);
        if (s < NC) ref_hold[s] = int'(d);
    endtask

    task automatic read_reg(input logic [7:0] s, input string tag);
        logic [7:0] v;
        bus_start();
        send_addr(DEV, 1'b0, 1'b1, "R1 own write address");
        send_sub(s);
        bus_start();
        send_addr(DEV, 1'b1, 1'b1, "R7 own read address");
        recv_byte(v, 1'b0);
        chk(int'(v) == model_read(int'(s)), tag, int'(v), model_read(int'(s)));
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R12 actual=hung expected=completion");
        summary();
    end

    initial begin
        logic [7:0] v;
        bit ack;
        for (int i = 0; i < NC; i++) begin
            ref_hold[i] = 0;
            ref_cmd[i] = 0;
        end
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk(cmd_q == '0, "R12 reset command bank", int'(cmd_q[7:0]), 0);
        chk(sda_oe == 1'b0, "R12 reset SDA released", int'(sda_oe), 0);
        cmp_en = 1'b1;

        // Staged writes, read-back before STOP, then commit
        bus_start();
        send_addr(DEV, 1'b0, 1'b1, "R1 own write address");
        write_pair(8'h02, 8'h5A);
        write_pair(8'h07, 8'hC3);
        chk(cmd_q[2*8 +: 8] == 8'h00, "R3 no commit before STOP", int'(cmd_q[2*8 +: 8]), 0);
        bus_start();
        send_addr(DEV, 1'b0, 1'b1, "R1 own write address");
        send_sub(8'h02);
        bus_start();
        send_addr(DEV, 1'b1, 1'b1, "R7 own read address");
        recv_byte(v, 1'b0);
        chk(v == 8'h5A, "R9 staged read-back", int'(v), 'h5A);
        bus_stop();
        chk(cmd_q[2*8 +: 8] == 8'h5A, "R4 commit index 2", int'(cmd_q[2*8 +: 8]), 'h5A);
        chk(cmd_q[7*8 +: 8] == 8'hC3, "R6 second pair index 7", int'(cmd_q[7*8 +: 8]), 'hC3);
        read_reg(8'h03, "R6 no auto-increment index 3");

        // Repeated START to another device keeps staged data
        bus_start();
        send_addr(DEV, 1'b0, 1'b1, "R5 own write address");
        write_pair(8'h05, 8'h11);
        bus_start();
        send_addr(7'h22, 1'b0, 1'b0, "R1 foreign address not acked");
        send_byte(8'h05, ack);
        chk(!ack, "R1 foreign byte ignored", int'(ack), 0);
        chk(cmd_q[5*8 +: 8] == 8'h00, "R5 held until final STOP", int'(cmd_q[5*8 +: 8]), 0);
        bus_stop();
        chk(cmd_q[5*8 +: 8] == 8'h11, "R5 committed at final STOP", int'(cmd_q[5*8 +: 8]), 'h11);

        // Polling with the persistent pointer
        bus_start();
        send_addr(DEV, 1'b1, 1'b1, "R8 poll read address");
        recv_byte(v, 1'b1);
        chk(v == 8'h11, "R8 first poll byte", int'(v), 'h11);
        recv_byte(v, 1'b0);
        chk(v == 8'h11, "R8 host ACK repeats same register", int'(v), 'h11);
        wq();
        chk(sda_oe == 1'b0 && sda_bus == 1'b1, "R8 released after NACK", int'(sda_oe), 0);
        bus_start();
        send_addr(DEV, 1'b1, 1'b1, "R8 poll again without STOP");
        recv_byte(v, 1'b0);
        chk(v == 8'h11, "R8 pointer persisted", int'(v), 'h11);
        bus_stop();

        // Status range
        bus_start();
        send_addr(DEV, 1'b0, 1'b1, "R10 own write address");
        write_pair(8'h10, 8'hFF);
        bus_stop();
        read_reg(8'h10, "R10 status byte 0");
        read_reg(8'h11, "R10 status byte 1");

        // Unmapped and boundary indices
        bus_start();
        send_addr(DEV, 1'b0, 1'b1, "R11 own write address");
        write_pair(8'h40, 8'h77);
        write_pair(8'h0D, 8'h99);
        write_pair(8'h0E, 8'h66);
        bus_stop();
        read_reg(8'h40, "R11 unmapped reads zero");
        read_reg(8'h0E, "R11 index past last command reads zero");
        read_reg(8'h0D, "R11 last command index");
        chk(cmd_q[13*8 +: 8] == 8'h99, "R4 commit last index", int'(cmd_q[13*8 +: 8]), 'h99);

        // Empty transaction leaves the bank alone
        bus_start();
        bus_stop();
        chk(cmd_q[2*8 +: 8] == 8'h5A, "R4 empty START/STOP keeps values", int'(cmd_q[2*8 +: 8]), 'h5A);

        repeat (10) @(posedge clk);
        summary();
    end

endmodule